// File: doc/BRIEF.md
# Two-Residue Byte Codec over GF(2^8)

This block combines a data byte and a check-signature byte into one 16-bit word. The word is an element of the ring of degree-one polynomials over GF(2^8), reduced modulo y^2 + c1*y + c0. The modulus is the product of (y + a1) and (y + a2). The data byte is the residue modulo y + a1, and the signature byte is the residue modulo y + a2. Because the two residues sit orthogonally in one word, every later operation on the word acts on both of them. An error that changes the data without the matching change to the signature is therefore exposed when the word is decoded.

Software-independent setup is done once. The user places the two field constants on the configuration inputs and pulses a start. A small state machine then computes the inverse of (a1 XOR a2) by square-and-multiply and derives the two idempotents from it. After that, single-cycle encode and decode requests are served, each through one register stage.

The configuration state machine has these states:
- CFG_IDLE: the state after reset.
- CFG_POWER: one exponent bit is handled per cycle.
- CFG_FINISH: the idempotent coefficients are latched.
- CFG_READY: the block serves encode and decode requests.
- CFG_FAULT: the constants were rejected.

Its transitions are:
- start_accept: CFG_IDLE, CFG_READY or CFG_FAULT to CFG_POWER, taken on a start with valid constants.
- start_reject: the same three states to CFG_FAULT, taken on a start with invalid constants.
- power_done: CFG_POWER to CFG_FINISH, taken after the last exponent bit.
- latch_keys: CFG_FINISH to CFG_READY.

Top module: `crt_byte_codec`

## Requirements
- R1: Field products use the reduction polynomial x^8+x^4+x^3+x+1 (0x11B). Let s = a1 XOR a2. An encode of (xD, xC) returns enc_u = {u1, u0}, with u1 in bits 15:8, where u1 = (xD XOR xC)*s^-1 and u0 = (xD*a2 XOR xC*a1)*s^-1. This equals xD*i1 + xC*i2, with i1 = (y+a2)/s and i2 = (y+a1)/s.
- R2: A decode of dec_u = {u1, u0} returns dec_xd = u0 XOR u1*a1 (the residue modulo y+a1) and dec_xc = u0 XOR u1*a2 (the residue modulo y+a2).
- R3: Decoding an encoded word returns the original data byte and signature byte.
- R4: A request presented while cfg_ready is high produces its out_valid and result exactly one clock later.
- R5: A request presented while cfg_ready is low produces no out_valid pulse.
- R6: A start is accepted in CFG_IDLE, CFG_READY or CFG_FAULT. After an accepted start with valid constants, cfg_busy is high for 9 cycles and cfg_ready rises on the cycle after that. cfg_busy and cfg_ready are never high together.
- R7: A start with a1 equal to a2 sets cfg_error and leaves cfg_ready low.
- R8: A start with a2 equal to zero also sets cfg_error and leaves cfg_ready low, since that constant would make a coefficient of i1 zero.
- R9: A start while cfg_busy is high is ignored, and the configuration in progress completes.
- R10: During reset, cfg_busy, cfg_ready, cfg_error, enc_out_valid and dec_out_valid are all low.
- R11: A valid start issued from CFG_READY drops cfg_ready. Once cfg_ready returns, results use the new constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Start a configuration with cfg_a1 and cfg_a2 |
| cfg_a1 | input | 8 | Field constant of the data modulus |
| cfg_a2 | input | 8 | Field constant of the signature modulus |
| cfg_busy | output | 1 | Configuration in progress |
| cfg_ready | output | 1 | Idempotents valid; requests are served |
| cfg_error | output | 1 | Last start carried invalid constants |
| enc_valid | input | 1 | Encode request |
| enc_xd | input | 8 | Data byte to encode |
| enc_xc | input | 8 | Signature byte to encode |
| enc_out_valid | output | 1 | enc_u holds a new result |
| enc_u | output | 16 | Encoded ring element {u1, u0} |
| dec_valid | input | 1 | Decode request |
| dec_u | input | 16 | Ring element {u1, u0} to decode |
| dec_out_valid | output | 1 | dec_xd and dec_xc hold a new result |
| dec_xd | output | 8 | Residue modulo y+a1 |
| dec_xc | output | 8 | Residue modulo y+a2 |

## Verification
The assertions check the control behaviour on every cycle:
- request gating against cfg_ready, together with the one-cycle result latency;
- the exclusion of busy and ready;
- error never coexisting with ready;
- a busy phase always ending in ready.

The arithmetic needs the bench's scenarios, because its correctness is a property of field values. These scenarios cover encode and decode results across many byte pairs and several constant pairs, the round trip, both rejected-constant cases, the start ignored while busy, and a reconfiguration from the ready state.

// File: rtl/crt_ring_pkg.sv
`timescale 1ns/1ps
package crt_ring_pkg;
    localparam int unsigned SYM_W = 8;
    localparam int unsigned WORD_W = 2 * SYM_W;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11B;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [2:0] {
        CFG_IDLE,
        CFG_POWER,
        CFG_FINISH,
        CFG_READY,
        CFG_FAULT
    } cfg_state_t;

    // Carry-less product reduced by FIELD_POLY
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh = a;
        for (int i = 0; i < int'(SYM_W); i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else sh = sh << 1;
        end
        return acc;
    endfunction
endpackage

// File: rtl/crt_cfg_fsm.sv
`timescale 1ns/1ps
module crt_cfg_fsm
    import crt_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  sym_t a1_in,
    input  sym_t a2_in,
    output logic busy,
    output logic ready,
    output logic error,
    output sym_t key_a1,
    output sym_t key_a2,
    output sym_t inv_hi,
    output sym_t i1_lo,
    output sym_t i2_lo
);
    localparam int unsigned IDX_W = $clog2(SYM_W);
    localparam logic [SYM_W-1:0] INV_EXP = SYM_W'((1 << SYM_W) - 2);

    cfg_state_t state_q, state_d;
    sym_t a1_q, a2_q, sum_q, acc_q, inv_q, i1lo_q, i2lo_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic accept, bad_const;
    sym_t sq, step;

    assign bad_const = (a1_in == a2_in) || (a2_in == '0);
    assign accept = start && (state_q == CFG_IDLE || state_q == CFG_READY || state_q == CFG_FAULT);
    assign sq = gf_mul(acc_q, acc_q);
    assign step = INV_EXP[bit_idx_q] ? gf_mul(sq, sum_q) : sq;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE, CFG_READY, CFG_FAULT: begin
                if (start) state_d = bad_const ? CFG_FAULT : CFG_POWER;
            end
            CFG_POWER:  if (bit_idx_q == '0) state_d = CFG_FINISH;
            CFG_FINISH: state_d = CFG_READY;
            default:    state_d = CFG_IDLE;
        endcase
    end

    // datapath of the exponentiation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a1_q <= '0; a2_q <= '0; sum_q <= '0; acc_q <= '0;
            inv_q <= '0; i1lo_q <= '0; i2lo_q <= '0; bit_idx_q <= '0;
        end else if (accept) begin
            a1_q <= a1_in;
            a2_q <= a2_in;
            sum_q <= a1_in ^ a2_in;
            acc_q <= sym_t'(1);
            bit_idx_q <= IDX_W'(SYM_W - 1);
        end else if (state_q == CFG_POWER) begin
            acc_q <= step;
            if (bit_idx_q != '0) bit_idx_q <= bit_idx_q - 1'b1;
        end else if (state_q == CFG_FINISH) begin
            inv_q  <= acc_q;
            i1lo_q <= gf_mul(a2_q, acc_q);
            i2lo_q <= gf_mul(a1_q, acc_q);
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q == CFG_POWER) || (state_q == CFG_FINISH);
        ready = (state_q == CFG_READY);
        error = (state_q == CFG_FAULT);
        key_a1 = a1_q;
        key_a2 = a2_q;
        inv_hi = inv_q;
        i1_lo = i1lo_q;
        i2_lo = i2lo_q;
    end
endmodule

// File: rtl/crt_encoder.sv
`timescale 1ns/1ps
module crt_encoder
    import crt_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              req,
    input  sym_t              xd,
    input  sym_t              xc,
    input  sym_t              inv_hi,
    input  sym_t              i1_lo,
    input  sym_t              i2_lo,
    output logic              out_valid,
    output logic [WORD_W-1:0] u
);
    sym_t hi_c, lo_c;
    assign hi_c = gf_mul(xd, inv_hi) ^ gf_mul(xc, inv_hi);
    assign lo_c = gf_mul(xd, i1_lo) ^ gf_mul(xc, i2_lo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            u <= '0;
        end else begin
            out_valid <= req && ready;
            if (req && ready) u <= {hi_c, lo_c};
        end
    end
endmodule

// File: rtl/crt_decoder.sv
`timescale 1ns/1ps
module crt_decoder
    import crt_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              req,
    input  logic [WORD_W-1:0] u,
    input  sym_t              a1,
    input  sym_t              a2,
    output logic              out_valid,
    output sym_t              xd,
    output sym_t              xc
);
    sym_t u_hi, u_lo;
    assign u_hi = u[WORD_W-1:SYM_W];
    assign u_lo = u[SYM_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            xd <= '0;
            xc <= '0;
        end else begin
            out_valid <= req && ready;
            if (req && ready) begin
                xd <= u_lo ^ gf_mul(u_hi, a1);
                xc <= u_lo ^ gf_mul(u_hi, a2);
            end
        end
    end
endmodule

// File: rtl/crt_byte_codec.sv
`timescale 1ns/1ps
module crt_byte_codec
    import crt_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [SYM_W-1:0]  cfg_a1,
    input  logic [SYM_W-1:0]  cfg_a2,
    output logic              cfg_busy,
    output logic              cfg_ready,
    output logic              cfg_error,
    input  logic              enc_valid,
    input  logic [SYM_W-1:0]  enc_xd,
    input  logic [SYM_W-1:0]  enc_xc,
    output logic              enc_out_valid,
    output logic [WORD_W-1:0] enc_u,
    input  logic              dec_valid,
    input  logic [WORD_W-1:0] dec_u,
    output logic              dec_out_valid,
    output logic [SYM_W-1:0]  dec_xd,
    output logic [SYM_W-1:0]  dec_xc
);
    sym_t key_a1, key_a2, inv_hi, i1_lo, i2_lo;

    crt_cfg_fsm cfg_i (
        .clk(clk), .rst_n(rst_n), .start(cfg_start),
        .a1_in(cfg_a1), .a2_in(cfg_a2),
        .busy(cfg_busy), .ready(cfg_ready), .error(cfg_error),
        .key_a1(key_a1), .key_a2(key_a2), .inv_hi(inv_hi),
        .i1_lo(i1_lo), .i2_lo(i2_lo)
    );

    crt_encoder enc_i (
        .clk(clk), .rst_n(rst_n), .ready(cfg_ready), .req(enc_valid),
        .xd(enc_xd), .xc(enc_xc), .inv_hi(inv_hi), .i1_lo(i1_lo), .i2_lo(i2_lo),
        .out_valid(enc_out_valid), .u(enc_u)
    );

    crt_decoder dec_i (
        .clk(clk), .rst_n(rst_n), .ready(cfg_ready), .req(dec_valid),
        .u(dec_u), .a1(key_a1), .a2(key_a2),
        .out_valid(dec_out_valid), .xd(dec_xd), .xc(dec_xc)
    );
endmodule

// File: rtl/crt_byte_codec_chk.sv
`timescale 1ns/1ps
module crt_byte_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_busy,
    input logic cfg_ready,
    input logic cfg_error,
    input logic enc_valid,
    input logic enc_out_valid,
    input logic dec_valid,
    input logic dec_out_valid
);
    // R4
    enc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && cfg_ready) |=> enc_out_valid);
    // R5
    enc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc_valid && cfg_ready) |=> !enc_out_valid);
    // R4
    dec_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && cfg_ready) |=> dec_out_valid);
    // R5
    dec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && cfg_ready) |=> !dec_out_valid);
    // R6
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_busy && cfg_ready));
    // R7
    error_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !cfg_ready);
    // R9
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |=> (cfg_busy || cfg_ready));
endmodule

bind crt_byte_codec crt_byte_codec_chk chk_i (.*);

// File: tb/crt_byte_codec_tb_top.sv
`timescale 1ns/1ps
module crt_byte_codec_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic cfg_start, enc_valid, dec_valid;
    logic [7:0] cfg_a1, cfg_a2, enc_xd, enc_xc;
    logic [15:0] dec_u;
    logic cfg_busy, cfg_ready, cfg_error, enc_out_valid, dec_out_valid;
    logic [15:0] enc_u;
    logic [7:0] dec_xd, dec_xc;

    crt_byte_codec dut_i (.*);

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // log / antilog tables built from generator 3
    int ex[0:255];
    int lg[0:255];

    function automatic int rmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return ex[(lg[a] + lg[b]) % 255];
    endfunction

    function automatic int rinv(int s);
        return ex[(255 - lg[s]) % 255];
    endfunction

    // model state
    bit m_busy, m_ready, m_err;
    int m_cnt;
    int k_a1, k_a2, n_a1, n_a2;
    bit p_st, p_ev, p_dv;
    int p_a1, p_a2, p_xd, p_xc, p_du;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input bit st, input int a1, input int a2,
                        input bit ev, input int xd, input int xc,
                        input bit dv, input int du);
        bit e_ev, e_dv;
        int e_u, e_xd, e_xc, inv;
        @(negedge clk);
        e_ev = p_ev && m_ready;
        e_dv = p_dv && m_ready;
        e_u = 0; e_xd = 0; e_xc = 0;
        if (e_ev) begin
            inv = rinv(k_a1 ^ k_a2);
            e_u = (rmul(p_xd ^ p_xc, inv) << 8) | rmul(rmul(p_xd, k_a2) ^ rmul(p_xc, k_a1), inv);
        end
        if (e_dv) begin
            e_xd = (p_du & 255) ^ rmul(p_du >> 8, k_a1);
            e_xc = (p_du & 255) ^ rmul(p_du >> 8, k_a2);
        end
        if (p_st && !m_busy) begin
            if (p_a1 == p_a2 || p_a2 == 0) begin
                m_err = 1; m_ready = 0;
            end else begin
                m_busy = 1; m_cnt = 9; m_ready = 0; m_err = 0;
                n_a1 = p_a1; n_a2 = p_a2;
            end
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 0; m_ready = 1; k_a1 = n_a1; k_a2 = n_a2;
            end
        end
        check(cfg_busy == m_busy, "R6", "cfg_busy", cfg_busy, m_busy);
        check(cfg_ready == m_ready, "R6", "cfg_ready", cfg_ready, m_ready);
        check(cfg_error == m_err, "R7", "cfg_error", cfg_error, m_err);
        check(enc_out_valid == e_ev, e_ev ? "R4" : "R5", "enc_out_valid", enc_out_valid, e_ev);
        check(dec_out_valid == e_dv, e_dv ? "R4" : "R5", "dec_out_valid", dec_out_valid, e_dv);
        if (e_ev) check(enc_u == e_u[15:0], "R1", "enc_u", enc_u, e_u);
        if (e_dv) begin
            check(dec_xd == e_xd[7:0], "R2", "dec_xd", dec_xd, e_xd);
            check(dec_xc == e_xc[7:0], "R2", "dec_xc", dec_xc, e_xc);
        end
        cfg_start = st; cfg_a1 = a1[7:0]; cfg_a2 = a2[7:0];
        enc_valid = ev; enc_xd = xd[7:0]; enc_xc = xc[7:0];
        dec_valid = dv; dec_u = du[15:0];
        p_st = st; p_a1 = a1 & 255; p_a2 = a2 & 255;
        p_ev = ev; p_xd = xd & 255; p_xc = xc & 255;
        p_dv = dv; p_du = du & 65535;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic configure(input int a1, input int a2);
        tick(1, a1, a2, 0, 0, 0, 0, 0);
        idle(11);
    endtask

    task automatic round_trip(input int xd, input int xc);
        logic [15:0] w;
        tick(0, 0, 0, 1, xd, xc, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 0, 0);
        w = enc_u;
        tick(0, 0, 0, 0, 0, 0, 1, w);
        tick(0, 0, 0, 0, 0, 0, 0, 0);
        // R3
        check(dec_xd == xd[7:0], "R3", "round trip xd", dec_xd, xd);
        check(dec_xc == xc[7:0], "R3", "round trip xc", dec_xc, xc);
    endtask

    task automatic sweep(input int seed, input int n);
        int v = seed;
        for (int i = 0; i < n; i++) begin
            v = (v * 1103515245 + 12345) & 32'h7fffffff;
            tick(0, 0, 0, 1, v >> 8, v >> 16, 1, v >> 4);
        end
        tick(0, 0, 0, 1, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 255, 255, 1, 65535);
        tick(0, 0, 0, 1, 255, 0, 1, 16'h0100);
        idle(1);
    endtask

    initial begin
        int x;
        x = 1;
        for (int i = 0; i < 255; i++) begin
            ex[i] = x;
            lg[x] = i;
            x = x ^ ((x << 1) ^ (((x >> 7) & 1) ? 27 : 0));
            x = x & 255;
        end
        ex[255] = 1;
        lg[0] = 0;

        rst_n = 0;
        cfg_start = 0; cfg_a1 = 0; cfg_a2 = 0;
        enc_valid = 0; enc_xd = 0; enc_xc = 0; dec_valid = 0; dec_u = 0;
        m_busy = 0; m_ready = 0; m_err = 0; m_cnt = 0;
        k_a1 = 0; k_a2 = 0; n_a1 = 0; n_a2 = 0;
        p_st = 0; p_ev = 0; p_dv = 0; p_a1 = 0; p_a2 = 0; p_xd = 0; p_xc = 0; p_du = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R10
            check({cfg_busy, cfg_ready, cfg_error, enc_out_valid, dec_out_valid} == 5'b0,
                  "R10", "reset outputs",
                  {cfg_busy, cfg_ready, cfg_error, enc_out_valid, dec_out_valid}, 0);
        end
        rst_n = 1;

        // R5: requests before any configuration
        for (int i = 0; i < 4; i++) tick(0, 0, 0, 1, i, 3 * i, 1, 257 * i);
        idle(1);

        // R6 and R9: a second start during busy carries bad constants and must be ignored
        tick(1, 8'h02, 8'h03, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 1, 5, 6, 1, 7);
        tick(1, 8'h44, 8'h44, 0, 0, 0, 0, 0);
        idle(10);
        check(cfg_ready == 1'b1 && cfg_error == 1'b0, "R9", "ready after ignored start", cfg_ready, 1);

        // R1, R2 under the first constants
        sweep(17, 40);
        round_trip(8'h3C, 8'hA5);
        round_trip(8'h00, 8'hFF);

        // R11: reconfigure from ready with a request on the accepting cycle
        tick(1, 8'h57, 8'hC3, 1, 8'h12, 8'h34, 1, 16'hBEEF);
        tick(0, 0, 0, 1, 1, 2, 1, 3);
        check(cfg_ready == 1'b0, "R11", "ready drops on reconfig", cfg_ready, 0);
        idle(10);
        sweep(99, 40);
        round_trip(8'h80, 8'h01);

        // R7: equal constants
        tick(1, 8'h21, 8'h21, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 1, 9, 9, 1, 9);
        check(cfg_error == 1'b1 && cfg_ready == 1'b0, "R7", "equal constants rejected", cfg_error, 1);
        idle(3);

        // R8: zero second constant
        configure(8'h05, 8'h00);
        check(cfg_error == 1'b1 && cfg_ready == 1'b0, "R8", "zero a2 rejected", cfg_error, 1);
        tick(0, 0, 0, 1, 4, 4, 1, 4);
        idle(2);

        // recovery with a1 = 0
        configure(8'h00, 8'h01);
        sweep(5, 30);
        round_trip(8'hC7, 8'h19);
        idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule